// File: doc/BRIEF.md
# Selective Inter-Datapath Operand Forwarding Unit

This unit sits beside the decode stage of a core built from several parallel pipelined datapaths. Each datapath reports the destination register, write enable and result held in its two late pipeline registers: EX/MEM, the younger, and MEM/WB, the older. Each datapath also presents the source register numbers of the operation now in decode. For every consumer operand the unit decides whether a result still in flight can stand in for the register file read. It then loads the chosen value into that operand's ID/EX register.

Forwarding between datapaths runs only over a sparse set of bypass links, fixed at build time by the `LINK_MAP` matrix parameter. A link works in both directions: it is present if either the (a,b) bit or the (b,a) bit of the matrix is set, with bit `a*NUM_DP+b` standing for the pair (a,b). A datapath's own pipeline is always a legal source. A producer on an unlinked datapath is never used. A producer that has already left the bypass stages is not visible to the unit, so its value comes from the register file. Next to each operand value the unit reports a hit flag and a select code naming the chosen source.

Top module: `fwd_unit`

## Requirements
- R1: While `rstN` is low, every bit of `opValue`, `opSel` and `opHit` is 0.
- R2: Outputs are registered. The values seen after a rising clock edge depend only on the inputs sampled at that edge.
- R3: A consumer operand whose source register matches a valid destination in its own datapath's EX/MEM or MEM/WB stage is forwarded, whatever the link map holds.
- R4: A producer in another datapath is used only if the two datapaths are linked. The pair (a,b) is linked when bit `a*NUM_DP+b` or bit `b*NUM_DP+a` of `LINK_MAP` is set. The default map links datapaths 0 and 1, and datapaths 1 and 2.
- R5: A source register number of 0 never matches, and neither does a producer stage whose write enable is low.
- R6: When allowed matches exist in both stages, the EX/MEM stage is chosen over the MEM/WB stage.
- R7: When several allowed producers match within the chosen stage, the one with the lowest datapath index is chosen.
- R8: With no allowed match, the operand takes its `rfData` value, `opHit` is 0 and its `opSel` is 0.
- R9: The select code for operand k is `opSel[k*5 +: 5]`. Bit 4 holds the stage (0 for EX/MEM, 1 for MEM/WB) and bits 3:0 hold the producer's datapath index. Operand k belongs to datapath k/NUM_SRC.
- R10: On a hit, `opValue` equals the result held in the selected producer's selected stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| exMemWe | input | NUM_DP | Write enable of each datapath's EX/MEM stage |
| exMemRd | input | NUM_DP*REG_W | Destination register of each EX/MEM stage |
| exMemData | input | NUM_DP*DATA_W | Result held in each EX/MEM stage |
| memWbWe | input | NUM_DP | Write enable of each datapath's MEM/WB stage |
| memWbRd | input | NUM_DP*REG_W | Destination register of each MEM/WB stage |
| memWbData | input | NUM_DP*DATA_W | Result held in each MEM/WB stage |
| idSrc | input | NUM_DP*NUM_SRC*REG_W | Source register numbers of every decode operand |
| rfData | input | NUM_DP*NUM_SRC*DATA_W | Register file read value of every operand |
| opValue | output | NUM_DP*NUM_SRC*DATA_W | ID/EX operand values |
| opSel | output | NUM_DP*NUM_SRC*5 | Per-operand select code |
| opHit | output | NUM_DP*NUM_SRC | Per-operand forwarded flag |

## Verification
Directed patterns each isolate one rule:
- Matches on the consumer's own datapath show that own forwarding ignores the link map.
- The same match placed on a linked and on an unlinked datapath, with the link bit set in the opposite triangle of the matrix, tests both link gating and symmetry.
- Register 0 and cleared write enables test the match filters.
- Matching producers in both stages and in several datapaths test stage priority and index priority.

Randomised cycles then draw register numbers from a tiny range, so that multiple simultaneous matches are common. A behavioural model checks value, code and flag for every operand on every clock.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int IDX_W = 4;
  localparam int SEL_W = IDX_W + 1;

  // Per-operand decision handed from control to datapath
  typedef struct packed {
    logic             hit;
    logic             fromWb;
    logic [IDX_W-1:0] src;
  } fwdStrobe_t;
endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int NUM_DP  = 4,
  parameter int NUM_SRC = 2,
  parameter int REG_W   = 5,
  parameter logic [NUM_DP*NUM_DP-1:0] LINK_MAP = 16'h0042
) (
  input  logic [NUM_DP-1:0]               exMemWe,
  input  logic [NUM_DP*REG_W-1:0]         exMemRd,
  input  logic [NUM_DP-1:0]               memWbWe,
  input  logic [NUM_DP*REG_W-1:0]         memWbRd,
  input  logic [NUM_DP*NUM_SRC*REG_W-1:0] idSrc,
  output fwdStrobe_t [NUM_DP*NUM_SRC-1:0] strobes
);
  localparam int NUM_OPS = NUM_DP * NUM_SRC;

  // Symmetric link matrix; own datapath always allowed
  logic [NUM_DP-1:0] linkOk [NUM_DP];
  for (genvar a = 0; a < NUM_DP; a++) begin : g_linkRow
    for (genvar b = 0; b < NUM_DP; b++) begin : g_linkCol
      assign linkOk[a][b] = (a == b) || LINK_MAP[a*NUM_DP+b] || LINK_MAP[b*NUM_DP+a];
    end
  end

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    localparam int CONS = k / NUM_SRC;
    logic [REG_W-1:0]  srcReg;
    logic [NUM_DP-1:0] exMatch;
    logic [NUM_DP-1:0] wbMatch;
    fwdStrobe_t        pick;

    assign srcReg = idSrc[k*REG_W +: REG_W];

    for (genvar p = 0; p < NUM_DP; p++) begin : g_cmp
      assign exMatch[p] = exMemWe[p] && (exMemRd[p*REG_W +: REG_W] == srcReg)
                          && (srcReg != '0) && linkOk[CONS][p];
      assign wbMatch[p] = memWbWe[p] && (memWbRd[p*REG_W +: REG_W] == srcReg)
                          && (srcReg != '0) && linkOk[CONS][p];
    end

    // Scan high to low so the lowest index wins; EX/MEM scanned last so it wins
    always_comb begin
      pick = '0;
      for (int p = NUM_DP - 1; p >= 0; p--) begin
        if (wbMatch[p]) begin
          pick.hit    = 1'b1;
          pick.fromWb = 1'b1;
          pick.src    = IDX_W'(p);
        end
      end
      for (int p = NUM_DP - 1; p >= 0; p--) begin
        if (exMatch[p]) begin
          pick.hit    = 1'b1;
          pick.fromWb = 1'b0;
          pick.src    = IDX_W'(p);
        end
      end
    end

    assign strobes[k] = pick;
  end
endmodule

// File: rtl/fwd_dpath.sv
module fwd_dpath
  import fwd_pkg::*;
#(
  parameter int NUM_DP  = 4,
  parameter int NUM_SRC = 2,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32,
  parameter logic [NUM_DP*NUM_DP-1:0] LINK_MAP = 16'h0042
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  fwdStrobe_t [NUM_DP*NUM_SRC-1:0]  strobes,
  input  logic [NUM_DP*DATA_W-1:0]         exMemData,
  input  logic [NUM_DP*DATA_W-1:0]         memWbData,
  input  logic [NUM_DP*NUM_SRC*REG_W-1:0]  idSrc,
  input  logic [NUM_DP*NUM_SRC*DATA_W-1:0] rfData,
  output logic [NUM_DP*NUM_SRC*DATA_W-1:0] opValue,
  output logic [NUM_DP*NUM_SRC*SEL_W-1:0]  opSel,
  output logic [NUM_DP*NUM_SRC-1:0]        opHit
);
  localparam int NUM_OPS = NUM_DP * NUM_SRC;

  function automatic logic linkedPair(int a, int b);
    if (b >= NUM_DP) return 1'b0;
    return (a == b) || LINK_MAP[a*NUM_DP+b] || LINK_MAP[b*NUM_DP+a];
  endfunction

  logic [DATA_W-1:0] exArr [NUM_DP];
  logic [DATA_W-1:0] wbArr [NUM_DP];
  for (genvar p = 0; p < NUM_DP; p++) begin : g_unpack
    assign exArr[p] = exMemData[p*DATA_W +: DATA_W];
    assign wbArr[p] = memWbData[p*DATA_W +: DATA_W];
  end

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    localparam int CONS = k / NUM_SRC;
    logic [DATA_W-1:0] nextVal;

    always_comb begin
      nextVal = rfData[k*DATA_W +: DATA_W];
      if (strobes[k].hit) begin
        for (int p = 0; p < NUM_DP; p++) begin
          if (strobes[k].src == IDX_W'(p))
            nextVal = strobes[k].fromWb ? wbArr[p] : exArr[p];
        end
      end
    end

    // ID/EX operand register
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        opValue[k*DATA_W +: DATA_W] <= '0;
        opSel[k*SEL_W +: SEL_W]     <= '0;
        opHit[k]                    <= 1'b0;
      end else begin
        opValue[k*DATA_W +: DATA_W] <= nextVal;
        opSel[k*SEL_W +: SEL_W]     <= strobes[k].hit ? {strobes[k].fromWb, strobes[k].src} : '0;
        opHit[k]                    <= strobes[k].hit;
      end
    end

    p_nohit_rf_r8: assert property (@(posedge clk) disable iff (!rstN)
      !strobes[k].hit |=> (!opHit[k] && opSel[k*SEL_W +: SEL_W] == '0
                           && opValue[k*DATA_W +: DATA_W] == $past(rfData[k*DATA_W +: DATA_W])));

    p_link_only_r4: assert property (@(posedge clk) disable iff (!rstN)
      opHit[k] |-> linkedPair(CONS, int'(opSel[k*SEL_W +: IDX_W])));

    p_zero_src_r5: assert property (@(posedge clk) disable iff (!rstN)
      (idSrc[k*REG_W +: REG_W] == '0) |=> !opHit[k]);

    for (genvar p = 0; p < NUM_DP; p++) begin : g_chk
      p_ex_value_r10: assert property (@(posedge clk) disable iff (!rstN)
        (strobes[k].hit && !strobes[k].fromWb && strobes[k].src == IDX_W'(p))
        |=> opValue[k*DATA_W +: DATA_W] == $past(exMemData[p*DATA_W +: DATA_W]));
      p_wb_value_r10: assert property (@(posedge clk) disable iff (!rstN)
        (strobes[k].hit && strobes[k].fromWb && strobes[k].src == IDX_W'(p))
        |=> opValue[k*DATA_W +: DATA_W] == $past(memWbData[p*DATA_W +: DATA_W]));
    end
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int NUM_DP  = 4,
  parameter int NUM_SRC = 2,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32,
  parameter logic [NUM_DP*NUM_DP-1:0] LINK_MAP = 16'h0042
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_DP-1:0]                exMemWe,
  input  logic [NUM_DP*REG_W-1:0]          exMemRd,
  input  logic [NUM_DP*DATA_W-1:0]         exMemData,
  input  logic [NUM_DP-1:0]                memWbWe,
  input  logic [NUM_DP*REG_W-1:0]          memWbRd,
  input  logic [NUM_DP*DATA_W-1:0]         memWbData,
  input  logic [NUM_DP*NUM_SRC*REG_W-1:0]  idSrc,
  input  logic [NUM_DP*NUM_SRC*DATA_W-1:0] rfData,
  output logic [NUM_DP*NUM_SRC*DATA_W-1:0] opValue,
  output logic [NUM_DP*NUM_SRC*SEL_W-1:0]  opSel,
  output logic [NUM_DP*NUM_SRC-1:0]        opHit
);
  fwdStrobe_t [NUM_DP*NUM_SRC-1:0] strobes;

  fwd_ctrl #(
    .NUM_DP(NUM_DP), .NUM_SRC(NUM_SRC), .REG_W(REG_W), .LINK_MAP(LINK_MAP)
  ) ctrl_i (
    .exMemWe(exMemWe), .exMemRd(exMemRd), .memWbWe(memWbWe), .memWbRd(memWbRd),
    .idSrc(idSrc), .strobes(strobes)
  );

  fwd_dpath #(
    .NUM_DP(NUM_DP), .NUM_SRC(NUM_SRC), .REG_W(REG_W), .DATA_W(DATA_W), .LINK_MAP(LINK_MAP)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .exMemData(exMemData),
    .memWbData(memWbData), .idSrc(idSrc), .rfData(rfData),
    .opValue(opValue), .opSel(opSel), .opHit(opHit)
  );
endmodule

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;
  localparam int NDP = 4, NSRC = 2, RW = 5, DW = 32, SW = 5;
  localparam int NOPS = NDP * NSRC;

  logic clk = 1'b0;
  logic rstN;
  logic [NDP-1:0]       exWe, wbWe;
  logic [NDP*RW-1:0]    exRd, wbRd;
  logic [NDP*DW-1:0]    exData, wbData;
  logic [NOPS*RW-1:0]   idSrc;
  logic [NOPS*DW-1:0]   rfData;
  logic [NOPS*DW-1:0]   opValue;
  logic [NOPS*SW-1:0]   opSel;
  logic [NOPS-1:0]      opHit;

  logic [DW-1:0] expVal [NOPS];
  logic [SW-1:0] expSel [NOPS];
  logic          expHit [NOPS];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  fwd_unit dut_i (
    .clk(clk), .rstN(rstN),
    .exMemWe(exWe), .exMemRd(exRd), .exMemData(exData),
    .memWbWe(wbWe), .memWbRd(wbRd), .memWbData(wbData),
    .idSrc(idSrc), .rfData(rfData),
    .opValue(opValue), .opSel(opSel), .opHit(opHit)
  );

  // Default map: datapaths 0-1 and 1-2 linked
  function automatic bit linked(int c, int p);
    return (c == p) || (c == 0 && p == 1) || (c == 1 && p == 0)
        || (c == 1 && p == 2) || (c == 2 && p == 1);
  endfunction

  task automatic computeExpected();
    for (int k = 0; k < NOPS; k++) begin
      int c = k / NSRC;
      logic [RW-1:0] s = idSrc[k*RW +: RW];
      bit found = 0;
      expHit[k] = 0; expSel[k] = '0; expVal[k] = rfData[k*DW +: DW];
      if (s != 0) begin
        for (int p = 0; p < NDP; p++)
          if (!found && exWe[p] && exRd[p*RW +: RW] == s && linked(c, p)) begin
            found = 1; expHit[k] = 1; expSel[k] = {1'b0, 4'(p)}; expVal[k] = exData[p*DW +: DW];
          end
        for (int p = 0; p < NDP; p++)
          if (!found && wbWe[p] && wbRd[p*RW +: RW] == s && linked(c, p)) begin
            found = 1; expHit[k] = 1; expSel[k] = {1'b1, 4'(p)}; expVal[k] = wbData[p*DW +: DW];
          end
      end
    end
  endtask

  task automatic compare(string tag);
    for (int k = 0; k < NOPS; k++) begin
      checks++;
      if (opHit[k] !== expHit[k] || opSel[k*SW +: SW] !== expSel[k] || opValue[k*DW +: DW] !== expVal[k]) begin
        fails++;
        $display("FAIL %s op%0d: hit=%0b sel=%h val=%h expected hit=%0b sel=%h val=%h", tag, k,
                 opHit[k], opSel[k*SW +: SW], opValue[k*DW +: DW], expHit[k], expSel[k], expVal[k]);
      end
    end
  endtask

  task automatic clearInputs();
    exWe = '0; wbWe = '0; exRd = '0; wbRd = '0; idSrc = '0;
    for (int p = 0; p < NDP; p++) begin
      exData[p*DW +: DW] = $urandom; wbData[p*DW +: DW] = $urandom;
    end
    for (int k = 0; k < NOPS; k++) rfData[k*DW +: DW] = $urandom;
  endtask

  task automatic setEx(int p, bit we, int rd);
    exWe[p] = we; exRd[p*RW +: RW] = RW'(rd);
  endtask
  task automatic setWb(int p, bit we, int rd);
    wbWe[p] = we; wbRd[p*RW +: RW] = RW'(rd);
  endtask
  task automatic setSrc(int k, int r);
    idSrc[k*RW +: RW] = RW'(r);
  endtask

  // Inputs are set at a falling edge; result sampled at the next falling edge
  task automatic applyAndCheck(string tag);
    computeExpected();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    rstN = 1'b0;
    clearInputs();
    setEx(0, 1, 3); setSrc(0, 3);
    repeat (3) @(negedge clk);
    for (int k = 0; k < NOPS; k++) begin expHit[k] = 0; expSel[k] = '0; expVal[k] = '0; end
    compare("R1 reset");
    rstN = 1'b1;

    // R8 R2: matching numbers but no write enable, fresh rf values
    clearInputs();
    for (int p = 0; p < NDP; p++) begin setEx(p, 0, 3); setWb(p, 0, 3); end
    for (int k = 0; k < NOPS; k++) setSrc(k, 3);
    applyAndCheck("R8 R2 no-match");

    // R3: own pipeline forwarding on unlinked datapath 3
    clearInputs();
    setEx(3, 1, 9); setWb(3, 1, 10); setSrc(6, 9); setSrc(7, 10);
    applyAndCheck("R3 own");

    // R4: unlinked vs linked, reverse-triangle bit
    clearInputs();
    setEx(2, 1, 4); setSrc(0, 4); setSrc(2, 4); setSrc(6, 4);
    setWb(0, 1, 6); setSrc(3, 6); setSrc(5, 6);
    applyAndCheck("R4 link");

    // R5: register 0 and cleared write enable
    clearInputs();
    setEx(0, 1, 0); setSrc(0, 0); setEx(1, 0, 5); setSrc(2, 5);
    applyAndCheck("R5 filter");

    // R6 R9: EX/MEM beats MEM/WB
    clearInputs();
    setEx(1, 1, 7); setWb(0, 1, 7); setSrc(0, 7); setSrc(1, 7);
    applyAndCheck("R6 R9 stage priority");

    // R7: lowest index wins
    clearInputs();
    setEx(0, 1, 8); setEx(1, 1, 8); setEx(2, 1, 8); setSrc(3, 8); setSrc(4, 8);
    setWb(1, 1, 11); setWb(2, 1, 11); setSrc(2, 11);
    applyAndCheck("R7 index priority");

    // Random: tiny register range for frequent multiple matches
    for (int i = 0; i < 400; i++) begin
      clearInputs();
      for (int p = 0; p < NDP; p++) begin
        setEx(p, 1'($urandom), $urandom % 4);
        setWb(p, 1'($urandom), $urandom % 4);
      end
      for (int k = 0; k < NOPS; k++) setSrc(k, $urandom % 4);
      applyAndCheck("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule